// File: doc/BRIEF.md
# Bufferless Router Output Arbitration and Switch Control

This block steers flits through a router that keeps no input queues and has no virtual channels. Every input port sees the head of an elastic-buffered channel. Each flit names its own output port, because route computation for this hop ran in the previous hop. Each output port has its own arbiter. The arbiters are independent, so no global allocator is needed. An arbiter that grants a head flit locks its output to that input until the packet's tail flit has crossed. Packets therefore never interleave on an output. Flow control is ready/valid on both sides. Only an input that is moving a flit this cycle sees its ready asserted. All other inputs wait in place inside their channel.

Each output holds one register slot, and the output channel is driven from that slot. A flit that breaks the packet protocol is consumed and discarded, and a per-input error pulse reports it. Protocol breaks are a body or tail flit with no lock behind it, a U-turn, or a port number outside the router.

Top module: `bufless_sw`

## Requirements
- R1: While reset is high and on the first cycle after it, no output is valid, no error pulse is raised, no lock is held, and every round-robin pointer sits at input 0.
- R2: The flit layout is: payload in bits [DW-1:0], tail marker in bit DW, head marker in bit DW+1, and destination port in the top $clog2(NP) bits. A legal flit is moved unchanged to the output named by its destination field. It appears there one cycle after its input handshake. Flits from one input to one output keep their order.
- R3: Once a head flit without a tail marker is transferred, that output accepts flits only from the same input until a flit with the tail marker is transferred.
- R4: A flit with both head and tail set is a whole packet. It releases the output in the same transfer, so another input can be transferred on the very next cycle.
- R5: Among head flits that want an unlocked output, the search starts at that output's pointer and wraps upward. Transferring a tail flit moves the pointer to the winning input plus one, modulo NP.
- R6: in_ready is high only for an input whose flit is transferred this cycle. That requires the output slot to be empty or out_ready to be high. It is also high for a discarded flit. At most one input is granted per output.
- R7: While an output is valid and out_ready is low, out_valid and out_flit stay unchanged.
- R8: A body or tail flit (head marker 0) is an error if its input does not hold the lock of its destination output. It is consumed (in_ready high), never forwarded, and raises proto_err for that input on the next cycle.
- R9: A flit whose destination equals its own input index, or is NP or above, is handled the same way as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NP | Flit present at each input |
| in_flit | input | NP*FW | Input flits, input i at [i*FW +: FW] |
| in_ready | output | NP | Flit accepted this cycle (combinational from state and out_ready) |
| out_valid | output | NP | Output slot holds a flit |
| out_flit | output | NP*FW | Output flits, output o at [o*FW +: FW] |
| out_ready | input | NP | Downstream channel accepts the output flit |
| proto_err | output | NP | One-cycle pulse: a flit from that input was discarded |

## Verification
The assertions assume that each input's channel behaves like an elastic buffer. Once a flit is offered, it stays unchanged until the handshake. An input's packets are also well formed, apart from the error cases deliberately applied. The bench drivers keep a flit and its valid steady until they see in_ready. Error flits are issued only as isolated, single-cycle offers. Back-pressure on out_ready comes from a pseudo-random sequence, and out_ready is always driven to a defined value.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  // Field positions inside a flit, given the payload width.
  function automatic int tail_pos(input int dw);
    return dw;
  endfunction
  function automatic int head_pos(input int dw);
    return dw + 1;
  endfunction
  function automatic int dest_lsb(input int dw);
    return dw + 2;
  endfunction
endpackage

// File: rtl/bsw_rr_pick.sv
module bsw_rr_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [IW:0]   sum;
  logic [IW-1:0] cand;

  // Scan from ptr upward with wrap-around; the first requester wins.
  always_comb begin
    gnt  = '0;
    idx  = '0;
    any  = 1'b0;
    sum  = '0;
    cand = '0;
    for (int k = 0; k < N; k++) begin
      sum = {1'b0, ptr} + (IW+1)'(k);
      if (sum >= (IW+1)'(N)) sum = sum - (IW+1)'(N);
      cand = sum[IW-1:0];
      if (!any && req[cand]) begin
        any       = 1'b1;
        gnt[cand] = 1'b1;
        idx       = cand;
      end
    end
  end
endmodule

// File: rtl/bsw_out_port.sv
module bsw_out_port #(
  parameter int N  = 5,
  parameter int DW = 16,
  parameter int IW = 3,
  parameter int ID = 0,
  parameter int FW = DW + 2 + IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  head,
  input  logic [N-1:0]  tail,
  input  logic [N*FW-1:0] flits,
  input  logic          out_ready,
  output logic [N-1:0]  gnt,
  output logic          locked,
  output logic [IW-1:0] owner,
  output logic          out_valid,
  output logic [FW-1:0] out_flit
);
  localparam logic [N-1:0] SELF = N'(1) << ID;

  logic [IW-1:0] ptr_q, owner_q, win_idx;
  logic          lock_q, ov_q, space, win_any, xfer, win_tail;
  logic [FW-1:0] of_q, win_flit;
  logic [N-1:0]  own_oh, cand, pick;

  always_comb begin
    own_oh = '0;
    own_oh[owner_q] = 1'b1;
  end

  // Locked: only the owner may continue. Unlocked: head flits compete.
  assign cand  = lock_q ? (req & own_oh) : (req & head & ~SELF);
  assign space = !ov_q || out_ready;

  bsw_rr_pick #(.N(N), .IW(IW)) i_pick (
    .req (cand),
    .ptr (ptr_q),
    .gnt (pick),
    .idx (win_idx),
    .any (win_any)
  );

  assign xfer     = win_any && space;
  assign gnt      = xfer ? pick : '0;
  assign win_flit = flits[win_idx*FW +: FW];
  assign win_tail = tail[win_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      owner_q <= '0;
      lock_q  <= 1'b0;
      ov_q    <= 1'b0;
      of_q    <= '0;
    end else begin
      if (xfer) begin
        ov_q <= 1'b1;
        of_q <= win_flit;
        if (win_tail) begin
          lock_q <= 1'b0;
          ptr_q  <= (win_idx == IW'(N-1)) ? '0 : win_idx + 1'b1;
        end else begin
          lock_q  <= 1'b1;
          owner_q <= win_idx;
        end
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign locked    = lock_q;
  assign owner     = owner_q;
  assign out_valid = ov_q;
  assign out_flit  = of_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !ov_q && !lock_q && ptr_q == '0);
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (rst)
    ov_q && !out_ready |=> ov_q && $stable(of_q));
  a_r6_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  a_r3_lock_kept: assert property (@(posedge clk) disable iff (rst)
    lock_q && !(xfer && win_tail) |=> lock_q && $stable(owner_q));
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ptr_q < IW'(N));
endmodule

// File: rtl/bufless_sw.sv
module bufless_sw #(
  parameter int NP = 5,
  parameter int DW = 16,
  localparam int IW = $clog2(NP),
  localparam int FW = DW + 2 + IW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NP-1:0]   in_valid,
  input  logic [NP*FW-1:0] in_flit,
  output logic [NP-1:0]   in_ready,
  output logic [NP-1:0]   out_valid,
  output logic [NP*FW-1:0] out_flit,
  input  logic [NP-1:0]   out_ready,
  output logic [NP-1:0]   proto_err
);
  import bsw_pkg::*;

  localparam int HP = head_pos(DW);
  localparam int TP = tail_pos(DW);
  localparam int DL = dest_lsb(DW);

  logic [IW-1:0] dst    [NP];
  logic [IW-1:0] own_a  [NP];
  logic [NP-1:0] req_m  [NP];
  logic [NP-1:0] gnt_m  [NP];
  logic [NP-1:0] hd, tl, bad, own_lock, err_now, gnt_any, lk, err_q;

  // Per-input decode and protocol check.
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      dst[i]      = in_flit[i*FW + DL +: IW];
      hd[i]       = in_flit[i*FW + HP];
      tl[i]       = in_flit[i*FW + TP];
      bad[i]      = ({1'b0, dst[i]} >= (IW+1)'(NP)) || (dst[i] == IW'(i));
      own_lock[i] = 1'b0;
      if (!bad[i]) own_lock[i] = lk[dst[i]] && (own_a[dst[i]] == IW'(i));
      err_now[i]  = in_valid[i] && (bad[i] || (!hd[i] && !own_lock[i]));
    end
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req_m[o][i] = in_valid[i] && !err_now[i] && (dst[i] == IW'(o));
    for (int i = 0; i < NP; i++) begin
      gnt_any[i] = 1'b0;
      for (int o = 0; o < NP; o++) gnt_any[i] = gnt_any[i] | gnt_m[o][i];
    end
  end

  genvar go;
  generate
    for (go = 0; go < NP; go++) begin : g_out
      bsw_out_port #(.N(NP), .DW(DW), .IW(IW), .ID(go), .FW(FW)) i_port (
        .clk       (clk),
        .rst       (rst),
        .req       (req_m[go]),
        .head      (hd),
        .tail      (tl),
        .flits     (in_flit),
        .out_ready (out_ready[go]),
        .gnt       (gnt_m[go]),
        .locked    (lk[go]),
        .owner     (own_a[go]),
        .out_valid (out_valid[go]),
        .out_flit  (out_flit[go*FW +: FW])
      );
    end
  endgenerate

  assign in_ready = err_now | gnt_any;

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_now;
  end
  assign proto_err = err_q;

  genvar gi;
  generate
    for (gi = 0; gi < NP; gi++) begin : g_chk
      a_r8_never_forwarded: assert property (@(posedge clk) disable iff (rst)
        err_now[gi] |-> !gnt_any[gi]);
      a_r9_bad_dest_drop: assert property (@(posedge clk) disable iff (rst)
        in_valid[gi] && bad[gi] |-> in_ready[gi] && !gnt_any[gi]);
    end
  endgenerate
endmodule

// File: tb/test_bufless_sw.sv
module test_bufless_sw;
  localparam int NP = 5, DW = 16, IW = 3, FW = DW + 2 + IW, RD = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic [NP-1:0]    in_valid, in_ready, out_valid, out_ready, proto_err;
  logic [NP*FW-1:0] in_flit, out_flit;
  logic             drv_v [NP];
  logic [FW-1:0]    drv_f [NP];

  always_comb
    for (int i = 0; i < NP; i++) begin
      in_valid[i]          = drv_v[i];
      in_flit[i*FW +: FW]  = drv_f[i];
    end

  bufless_sw #(.NP(NP), .DW(DW)) i_bufless_sw (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
    .out_ready(out_ready), .proto_err(proto_err));

  // Scoreboard: one ring per (source, output) stream.
  logic [FW-1:0] ring [NP*NP][RD];
  int wr_p [NP*NP];
  int rd_p [NP*NP];
  int total = 0, bad = 0, mtot = 0, mbad = 0;
  int err_exp = 0, err_seen = 0, cyc = 0;
  int seqn [NP];
  logic log_on = 1'b0;
  int rr_log [$];
  logic rdy_mode = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  function automatic logic [FW-1:0] mk(int dest, bit h, bit t, int src, int sq);
    return {IW'(dest), h, t, 3'(src), 13'(sq)};
  endfunction

  function automatic bit rep(bit ok, string rq, string what, longint act, longint exp);
    if (!ok) $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    return ok;
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!rep(ok, rq, what, act, exp)) bad++;
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  // Back-pressure source.
  initial begin
    out_ready = '1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = rdy_mode ? (lfsr[4:0] | lfsr[7:3]) : '1;
    end
  end

  // Monitor: pops and compares at each output transfer.
  logic          mid_on [NP];
  logic [2:0]    mid_src [NP];
  logic          hold_p [NP];
  logic [FW-1:0] hold_f [NP];
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total + mtot + 1, bad + mbad + 1);
      $finish;
    end
    if (rst) begin
      for (int o = 0; o < NP; o++) begin
        mid_on[o] = 1'b0; hold_p[o] = 1'b0;
      end
    end else begin
      err_seen += $countones(proto_err);
      for (int o = 0; o < NP; o++) begin
        logic [FW-1:0] f;
        int s, k;
        f = out_flit[o*FW +: FW];
        if (hold_p[o]) begin
          mtot++;
          if (!rep(out_valid[o] && f == hold_f[o], "R7", "stalled output changed", f, hold_f[o])) mbad++;
        end
        if (out_valid[o] && out_ready[o]) begin
          s = int'(f[DW-1 -: 3]);
          k = s * NP + o;
          mtot++;
          if (rd_p[k] == wr_p[k]) begin
            if (!rep(1'b0, "R2", "unexpected flit", f, 0)) mbad++;
          end else begin
            if (!rep(f == ring[k][rd_p[k] % RD], "R2", "flit mismatch", f, ring[k][rd_p[k] % RD])) mbad++;
            rd_p[k]++;
          end
          if (mid_on[o]) begin
            mtot++;
            if (!rep(s == int'(mid_src[o]), "R3", "packets interleaved", s, mid_src[o])) mbad++;
          end
          if (f[DW]) mid_on[o] = 1'b0;
          else begin mid_on[o] = 1'b1; mid_src[o] = 3'(s); end
          if (log_on && o == 0) rr_log.push_back(s);
        end
        hold_p[o] = out_valid[o] && !out_ready[o];
        hold_f[o] = f;
      end
    end
  end

  task automatic send_flit(int i, logic [FW-1:0] f, bit legal);
    bit ok;
    int k;
    drv_v[i] = 1'b1;
    drv_f[i] = f;
    do begin
      @(negedge clk);
      ok = in_ready[i];
      if (ok) begin
        if (legal) begin
          k = i * NP + int'(f[FW-1 -: IW]);
          ring[k][wr_p[k] % RD] = f;
          wr_p[k]++;
        end else err_exp++;
      end
      @(posedge clk); #1;
    end while (!ok);
    drv_v[i] = 1'b0;
  endtask

  task automatic send_pkt(int i, int dest, int len, int gap);
    for (int j = 0; j < len; j++) begin
      send_flit(i, mk(dest, j == 0, j == len - 1, i, seqn[i]), 1'b1);
      seqn[i]++;
      repeat (gap) tick();
    end
  endtask

  task automatic traffic(int i, int npk, int seed);
    for (int k = 0; k < npk; k++)
      send_pkt(i, (i + 1 + ((k * 3 + seed) % 4)) % NP, 1 + ((k + i + seed) % 4), (k + i) % 3);
  endtask

  task automatic drain;
    rdy_mode = 1'b0;
    repeat (20) tick();
    for (int k = 0; k < NP * NP; k++)
      chk(rd_p[k] == wr_p[k], "R2", "flits left undelivered", wr_p[k] - rd_p[k], 0);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    for (int i = 0; i < NP; i++) drv_v[i] = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == '0, "R1", "in_ready after reset", in_ready, 0);
    chk(proto_err == '0, "R1", "proto_err after reset", proto_err, 0);
    tick();
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      drv_v[i] = 1'b0; drv_f[i] = '0; seqn[i] = 0;
    end
    for (int k = 0; k < NP * NP; k++) begin wr_p[k] = 0; rd_p[k] = 0; end
    do_reset();

    // R2: single-flit packets, several sources and destinations.
    send_pkt(0, 3, 1, 0);
    send_pkt(4, 1, 1, 0);
    send_pkt(2, 0, 1, 1);
    send_pkt(1, 4, 3, 0);
    drain();

    // R3 / R6: output held by a gapped packet; a competitor must stall.
    do_reset();
    fork
      send_pkt(1, 2, 3, 4);
      begin tick(); send_pkt(3, 2, 1, 0); end
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk(in_valid[3] && !in_ready[3], "R6", "ready to locked-out input", in_ready[3], 0);
        @(negedge clk);
        chk(in_valid[3] && !in_ready[3], "R3", "lock not held during gap", in_ready[3], 0);
      end
    join
    drain();

    // R4: two whole packets back to back on one output.
    do_reset();
    fork
      send_flit(1, mk(2, 1, 1, 1, 900), 1'b1);
      send_flit(3, mk(2, 1, 1, 3, 901), 1'b1);
      begin
        @(negedge clk); @(negedge clk);
        chk(out_valid[2] && out_flit[2*FW + DW - 1 -: 3] == 3'd1, "R4", "first whole packet src", out_flit[2*FW + DW - 1 -: 3], 1);
        @(negedge clk);
        chk(out_valid[2] && out_flit[2*FW + DW - 1 -: 3] == 3'd3, "R4", "next-cycle packet src", out_flit[2*FW + DW - 1 -: 3], 3);
      end
    join
    drain();

    // R5: round-robin order among four steady requesters.
    do_reset();
    begin
      int base;
      base = rr_log.size();
      log_on = 1'b1;
      fork
        for (int n = 0; n < 6; n++) send_pkt(1, 0, 1, 0);
        for (int n = 0; n < 6; n++) send_pkt(2, 0, 1, 0);
        for (int n = 0; n < 6; n++) send_pkt(3, 0, 1, 0);
        for (int n = 0; n < 6; n++) send_pkt(4, 0, 1, 0);
      join
      drain();
      log_on = 1'b0;
      chk(rr_log.size() - base == 24, "R5", "grant count", rr_log.size() - base, 24);
      for (int n = 0; n < 24 && base + n < rr_log.size(); n++)
        chk(rr_log[base + n] == (n % 4) + 1, "R5", "grant order", rr_log[base + n], (n % 4) + 1);
    end

    // R8 / R9: malformed flits are discarded and flagged.
    do_reset();
    send_flit(2, mk(4, 0, 0, 2, 1), 1'b0);
    @(negedge clk);
    chk(proto_err == 5'b00100, "R8", "body flit without lock", proto_err, 5'b00100);
    chk(out_valid == '0, "R8", "body flit forwarded", out_valid, 0);
    tick();
    send_flit(3, mk(3, 1, 1, 3, 2), 1'b0);
    @(negedge clk);
    chk(proto_err == 5'b01000, "R9", "u-turn flit", proto_err, 5'b01000);
    tick();
    send_flit(0, mk(6, 1, 1, 0, 3), 1'b0);
    @(negedge clk);
    chk(proto_err == 5'b00001, "R9", "out-of-range port", proto_err, 5'b00001);
    chk(out_valid == '0, "R9", "bad flit forwarded", out_valid, 0);
    tick();
    send_flit(1, mk(2, 1, 0, 1, 4), 1'b1);
    send_flit(1, mk(3, 0, 0, 1, 5), 1'b0);
    @(negedge clk);
    chk(proto_err == 5'b00010, "R8", "body flit to unowned output", proto_err, 5'b00010);
    tick();
    send_flit(1, mk(2, 0, 1, 1, 6), 1'b1);
    drain();

    // R2 / R6 / R7: mixed traffic under random back-pressure.
    do_reset();
    rdy_mode = 1'b1;
    fork
      traffic(0, 20, 0);
      traffic(1, 20, 1);
      traffic(2, 20, 2);
      traffic(3, 20, 3);
      traffic(4, 20, 1);
    join
    drain();
    tick();
    chk(err_seen == err_exp, "R8", "error pulse count", err_seen, err_exp);

    $display("test done: total=%0d bad=%0d", total + mtot, bad + mbad);
    $finish;
  end
endmodule